// File: doc/BRIEF.md
# Unconditional Branch Target Unit

This unit sits beside the fetch stage and turns one 32-bit instruction word into the next fetch address. It needs the word, the address that word was fetched from, and a valid strobe. A word that carries the unconditional-branch opcode redirects fetch. A word with any other opcode, or a cycle with the strobe low, advances fetch by one instruction (four bytes).

The branch word holds three fields: a 24-bit word displacement, an addressing-mode bit and a link bit. The unit shifts the displacement left by two to make a byte offset and sign-extends that offset to the address width. The result is either added to the current address or used on its own as an absolute target. When the link bit is set, the address of the following instruction is sent out as a link-register write. All outputs are registered: they appear one clock after the inputs are sampled.

Top module: `ubt_top`

## Requirements
- R1: While `rst_n` is low, `nxt_addr`, `lnk_data` and `lnk_wdata` read zero, and `taken` and `lnk_we` read low, on the clock edge after reset is sampled.
- R2: A word whose bits [31:26] equal 18 (decimal), presented with `in_valid` high, drives `taken` high in the next cycle.
- R3: For a branch with bit 1 clear (relative mode), `nxt_addr` becomes `in_pc` plus the byte offset. The byte offset is bits [25:2] shifted left by two and sign-extended to 32 bits.
- R4: For a branch with bit 1 set (absolute mode), `nxt_addr` becomes the sign-extended byte offset alone, whatever `in_pc` is.
- R5: The displacement is signed. A negative relative displacement moves fetch backwards. An absolute displacement with bit 25 set lands in the top 32 MB (for example, 0xFE000000).
- R6: For a branch with bit 0 set, `lnk_we` is high for exactly that one output cycle, and `lnk_data` then holds `in_pc + 4`.
- R7: For a branch with bit 0 clear, `lnk_we` stays low and `lnk_data` keeps its previous value.
- R8: A word with any other value in bits [31:26] gives `nxt_addr = in_pc + 4`, `taken` low and no link write, even when bit 0 is set.
- R9: While `in_valid` is low, the outputs are `nxt_addr = in_pc + 4` with `taken` and `lnk_we` low, whatever the instruction word holds.
- R10: Outputs follow inputs with exactly one cycle of latency. Branches applied on consecutive cycles each give their own result.
- R11: Address arithmetic wraps modulo 2^32, for both the target sum and the sequential address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word and address are valid this cycle |
| in_instr | input | 32 | Instruction word, opcode in bits [31:26] |
| in_pc | input | 32 | Address the word was fetched from |
| nxt_addr | output | 32 | Registered next fetch address |
| taken | output | 1 | Registered redirect flag, high for one cycle per valid branch |
| lnk_we | output | 1 | Registered link-register write enable |
| lnk_data | output | 32 | Link value last written; holds while no write occurs |

## Verification
The bench builds the unit with its default parameters:
- 32-bit addresses and instruction words
- a 6-bit opcode with branch value 18
- a 24-bit displacement on 4-byte instructions

With these values, the full 26-bit signed reach is exercised: the backward relative jump, the absolute landing at 0xFE000000, and the wrap of a relative target past 2^32. The bench then runs a long pseudo-random mix of branch and non-branch words, with both mode bits, both link bits and the strobe low. This confirms that link data holds across non-writing cycles.

// File: rtl/ubt_pkg.sv
// Package: ubt_pkg
// Shared definitions for the unconditional branch target unit.
// Assumes the mode bit value 1 selects absolute addressing.
package ubt_pkg;

    // Target addressing mode carried by the instruction word
    typedef enum logic {
        MODE_REL = 1'b0,
        MODE_ABS = 1'b1
    } addr_mode_e;

    // Default field layout, MSB-first: opcode, displacement, mode, link
    localparam int DEF_INSTR_W   = 32;
    localparam int DEF_OPC_W     = 6;
    localparam int DEF_LI_W      = 24;
    localparam int DEF_BR_OPCODE = 18;
    localparam int DEF_INSTR_B   = 4;

endpackage

// File: rtl/ubt_field_decode.sv
// Module: ubt_field_decode
// Splits an instruction word into opcode match, displacement, mode and link.
// Assumes INSTR_W == OPC_W + LI_W + 2: the opcode is at the top, the
// displacement follows, then the mode bit (bit 1) and link bit (bit 0).
module ubt_field_decode
    import ubt_pkg::*;
#(
    parameter int INSTR_W   = DEF_INSTR_W,
    parameter int OPC_W     = DEF_OPC_W,
    parameter int LI_W      = DEF_LI_W,
    parameter int BR_OPCODE = DEF_BR_OPCODE
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               is_branch,
    output logic [LI_W-1:0]    disp,
    output addr_mode_e         mode,
    output logic               link
);

    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int DISP_LSB = OPC_LSB - LI_W;

    logic [OPC_W-1:0] opcode;

    // Field extraction and opcode comparison
    always_comb begin
        opcode    = instr[INSTR_W-1 -: OPC_W];
        disp      = instr[DISP_LSB +: LI_W];
        mode      = addr_mode_e'(instr[1]);
        link      = instr[0];
        is_branch = (opcode == OPC_W'(BR_OPCODE));
    end

endmodule

// File: rtl/ubt_target_calc.sv
// Module: ubt_target_calc
// Forms the byte offset from the word displacement, sign-extends it and
// selects a relative or absolute target; also forms the sequential address.
// Assumes INSTR_BYTES is a power of two; arithmetic wraps at ADDR_W bits.
module ubt_target_calc
    import ubt_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LI_W        = DEF_LI_W,
    parameter int INSTR_BYTES = DEF_INSTR_B
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [LI_W-1:0]   disp,
    input  addr_mode_e        mode,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] seq_addr
);

    localparam int SHIFT = $clog2(INSTR_BYTES);
    localparam int OFF_W = LI_W + SHIFT;

    logic [OFF_W-1:0]  off_raw;
    logic [ADDR_W-1:0] off_ext;

    // Word displacement to byte offset
    assign off_raw = {disp, {SHIFT{1'b0}}};

    // Sign extension or truncation to the address width
    generate
        if (ADDR_W > OFF_W) begin : g_extend
            assign off_ext = {{(ADDR_W-OFF_W){off_raw[OFF_W-1]}}, off_raw};
        end else begin : g_trunc
            assign off_ext = off_raw[ADDR_W-1:0];
        end
    endgenerate

    // Target and sequential address selection
    always_comb begin
        seq_addr = pc + ADDR_W'(INSTR_BYTES);
        target   = (mode == MODE_ABS) ? off_ext : (pc + off_ext);
    end

endmodule

// File: rtl/ubt_out_reg.sv
// Module: ubt_out_reg
// Output registers: redirect, next address and link-register update.
// Assumes synchronous active-low reset; link data holds unless written.
module ubt_out_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic              link_wr,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              taken,
    output logic              lnk_we,
    output logic [ADDR_W-1:0] lnk_data
);

    // Next address, redirect flag and link strobe, refreshed every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_addr <= '0;
            taken    <= 1'b0;
            lnk_we   <= 1'b0;
        end else begin
            nxt_addr <= redirect ? target : seq_addr;
            taken    <= redirect;
            lnk_we   <= link_wr;
        end
    end

    // Link value, loaded only on a link write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lnk_data <= '0;
        end else if (link_wr) begin
            lnk_data <= seq_addr;
        end
    end

endmodule

// File: rtl/ubt_top.sv
// Module: ubt_top
// Unconditional branch target unit: decodes a branch word, computes the next
// fetch address and the link-register update, all registered one cycle later.
// Assumes word-aligned addresses and a fixed-length instruction encoding.
module ubt_top
    import ubt_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int INSTR_W     = DEF_INSTR_W,
    parameter int OPC_W       = DEF_OPC_W,
    parameter int LI_W        = DEF_LI_W,
    parameter int BR_OPCODE   = DEF_BR_OPCODE,
    parameter int INSTR_BYTES = DEF_INSTR_B
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    input  logic [ADDR_W-1:0]  in_pc,
    output logic [ADDR_W-1:0]  nxt_addr,
    output logic               taken,
    output logic               lnk_we,
    output logic [ADDR_W-1:0]  lnk_data
);

    logic              dec_br;
    logic [LI_W-1:0]   dec_disp;
    addr_mode_e        dec_mode;
    logic              dec_link;
    logic [ADDR_W-1:0] calc_target;
    logic [ADDR_W-1:0] calc_seq;
    logic              redirect;
    logic              link_wr;

    ubt_field_decode #(
        .INSTR_W  (INSTR_W),
        .OPC_W    (OPC_W),
        .LI_W     (LI_W),
        .BR_OPCODE(BR_OPCODE)
    ) u_dec (
        .instr    (in_instr),
        .is_branch(dec_br),
        .disp     (dec_disp),
        .mode     (dec_mode),
        .link     (dec_link)
    );

    ubt_target_calc #(
        .ADDR_W     (ADDR_W),
        .LI_W       (LI_W),
        .INSTR_BYTES(INSTR_BYTES)
    ) u_calc (
        .pc      (in_pc),
        .disp    (dec_disp),
        .mode    (dec_mode),
        .target  (calc_target),
        .seq_addr(calc_seq)
    );

    // Qualify decode with the strobe
    always_comb begin
        redirect = in_valid && dec_br;
        link_wr  = redirect && dec_link;
    end

    ubt_out_reg #(
        .ADDR_W(ADDR_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .redirect(redirect),
        .link_wr (link_wr),
        .target  (calc_target),
        .seq_addr(calc_seq),
        .nxt_addr(nxt_addr),
        .taken   (taken),
        .lnk_we  (lnk_we),
        .lnk_data(lnk_data)
    );

endmodule

// File: rtl/ubt_checker.sv
// Module: ubt_checker
// Temporal checks on the ports of ubt_top, attached with bind below.
// Assumes rst_n is low from time zero.
module ubt_checker #(
    parameter int ADDR_W      = 32,
    parameter int INSTR_W     = 32,
    parameter int OPC_W       = 6,
    parameter int BR_OPCODE   = 18,
    parameter int INSTR_BYTES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [INSTR_W-1:0] in_instr,
    input logic [ADDR_W-1:0]  in_pc,
    input logic [ADDR_W-1:0]  nxt_addr,
    input logic               taken,
    input logic               lnk_we,
    input logic [ADDR_W-1:0]  lnk_data
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    logic past_ok;

    // Marks that the previous edge was already out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2: a redirect only follows a valid branch opcode
    p_taken_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && taken) |-> ($past(in_valid) &&
            ($past(in_instr[INSTR_W-1 -: OPC_W]) == OPC_W'(BR_OPCODE))));

    // R6: a link write carries the sequential address and needs a redirect
    p_link_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && lnk_we) |-> (taken && lnk_data == $past(in_pc) + STEP));

    // R7: link data holds whenever no write occurs
    p_link_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !lnk_we) |-> (lnk_data == $past(lnk_data)));

    // R9: strobe low gives the sequential address without redirect
    p_idle_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(in_valid)) |->
            (!taken && !lnk_we && nxt_addr == $past(in_pc) + STEP));

    // R10: a link write lasts a single cycle unless a new link branch arrived
    p_link_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && lnk_we && !in_valid) |=> !lnk_we);

endmodule

bind ubt_top ubt_checker #(
    .ADDR_W     (ADDR_W),
    .INSTR_W    (INSTR_W),
    .OPC_W      (OPC_W),
    .BR_OPCODE  (BR_OPCODE),
    .INSTR_BYTES(INSTR_BYTES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_instr(in_instr),
    .in_pc   (in_pc),
    .nxt_addr(nxt_addr),
    .taken   (taken),
    .lnk_we  (lnk_we),
    .lnk_data(lnk_data)
);

// File: tb/tb_ubt_top.sv
// Scoreboard bench for ubt_top: the driver pushes expected results, the
// monitor pops and compares them one cycle later.
module tb_ubt_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_pc = '0;
    logic [31:0] nxt_addr;
    logic        taken;
    logic        lnk_we;
    logic [31:0] lnk_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [31:0] nxt;
        logic        tk;
        logic        we;
        logic [31:0] ld;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [31:0] model_ld = '0;

    ubt_top dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_instr(in_instr),
        .in_pc   (in_pc),
        .nxt_addr(nxt_addr),
        .taken   (taken),
        .lnk_we  (lnk_we),
        .lnk_data(lnk_data)
    );

    // 250 MHz clock
    always #2 clk = ~clk;

    function automatic logic [31:0] mk_br(input logic [23:0] li, input bit aa, input bit lk);
        return {6'd18, li, aa, lk};
    endfunction

    // Driver: apply one vector for one cycle and push its expected result
    task automatic apply(input bit v, input logic [31:0] ins, input logic [31:0] pc, input string tag);
        exp_t e;
        logic [31:0] off;
        @(negedge clk);
        in_valid = v;
        in_instr = ins;
        in_pc    = pc;
        off = {{6{ins[25]}}, ins[25:2], 2'b00};
        e.nxt = pc + 32'd4;
        e.tk  = 1'b0;
        e.we  = 1'b0;
        if (v && ins[31:26] == 6'd18) begin
            e.tk  = 1'b1;
            e.nxt = ins[1] ? off : pc + off;
            if (ins[0]) begin
                e.we = 1'b1;
                model_ld = pc + 32'd4;
            end
        end
        e.ld = model_ld;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare just after the capturing edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (nxt_addr !== e.nxt || taken !== e.tk || lnk_we !== e.we || lnk_data !== e.ld) begin
                    fails++;
                    $display("FAIL %s: got nxt=%h tk=%b we=%b ld=%h exp nxt=%h tk=%b we=%b ld=%h",
                             t, nxt_addr, taken, lnk_we, lnk_data, e.nxt, e.tk, e.we, e.ld);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Stimulus
    initial begin
        logic [31:0] s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (nxt_addr !== 32'h0 || taken !== 1'b0 || lnk_we !== 1'b0 || lnk_data !== 32'h0) begin
            fails++;
            $display("FAIL R1: got nxt=%h tk=%b we=%b ld=%h expected all zero",
                     nxt_addr, taken, lnk_we, lnk_data);
        end
        rst_n = 1'b1;

        apply(1, mk_br(24'h000010, 0, 0), 32'h0000_1000, "R3");        // 0x1040
        apply(1, mk_br(24'hFFFFFC, 0, 0), 32'h0000_2000, "R5");        // 0x1FF0
        apply(1, mk_br(24'h0009CB, 1, 0), 32'h0040_0000, "R4");        // 0x272C
        apply(1, mk_br(24'h800000, 1, 0), 32'h0000_0100, "R5");        // 0xFE000000
        apply(1, mk_br(24'h000040, 0, 1), 32'h0000_3000, "R6");        // link 0x3004
        apply(1, mk_br(24'h000008, 0, 0), 32'h0000_3100, "R7");        // link holds
        apply(1, {6'd19, 24'h000123, 1'b0, 1'b1}, 32'h0000_4000, "R8"); // 0x4004
        apply(0, mk_br(24'h000100, 1, 1), 32'h0000_4800, "R9");        // 0x4804
        apply(1, mk_br(24'h000004, 0, 0), 32'hFFFF_FFF0, "R11");       // wraps to 0
        apply(1, {6'd17, 24'hFFFFFF, 1'b1, 1'b1}, 32'hFFFF_FFFC, "R11"); // wraps to 0
        apply(1, mk_br(24'h000200, 1, 1), 32'h0000_5000, "R6");        // link 0x5004
        apply(1, mk_br(24'h000001, 0, 1), 32'h0000_6000, "R10");       // back to back
        apply(1, mk_br(24'h000002, 1, 0), 32'h0000_7000, "R10");
        apply(1, mk_br(24'h000003, 0, 0), 32'h0000_8000, "R2");

        s = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ins;
            s = s ^ (s << 13);
            s = s ^ (s >> 17);
            s = s ^ (s << 5);
            ins = s;
            if (s[7]) ins[31:26] = 6'd18;
            apply(s[11] | s[12], ins, {s[29:2] ^ s[31:4], 2'b00}, "R10");
        end
        apply(0, 32'h0, 32'h0000_0010, "R9");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule